// File: doc/BRIEF.md
# Carrier Presence Qualifier with Hysteresis

This block turns a digital estimate of in-band received energy into a steady carrier-present flag. Two thresholds give hysteresis. The caller supplies the turn-on threshold. The turn-off threshold sits a fixed 2.5 dB below it. Energy is measured in steps of 0.5 dB, so the turn-off threshold is five steps lower.

A change of the flag must be qualified before it takes effect. The level must stay on the far side of the relevant threshold for an unbroken run of clock cycles. If the level crosses back before the run ends, the run starts again from zero. This lets the flag ride through short signal dropouts and keeps it from chattering.

The length of the run depends on a rate-class select. The fast class (600 and 1200 baud receive) uses a nominal 18 ms. The slow class (5, 75 and 150 baud receive) uses a nominal 64 ms. A second output asks the downstream receive path to force its data to mark whenever the carrier flag is low.

Top module: `carrier_detect_qual`

## Requirements
- R1: While reset is held and after it is released, carrier_o is 0 and clamp_o is 1. The flag stays low until a full turn-on qualification has completed.
- R2: With carrier_o at 0, slow_rate_i at 0 and level_i greater than or equal to thresh_on_i, carrier_o rises after exactly ON_FAST_MS*CYC_PER_MS consecutive qualifying rising clock edges (default 144). It is still 0 one edge before that.
- R3: A single cycle in which the qualifying condition is false restarts the count from zero. A following run needs the full count again.
- R4: With carrier_o at 1, a level greater than or equal to the turn-off threshold keeps carrier_o at 1 indefinitely. The turn-off threshold equals thresh_on_i minus HYST_STEPS (default 5 steps of 0.5 dB, that is 2.5 dB).
- R5: With carrier_o at 1, slow_rate_i at 0 and level_i strictly below the turn-off threshold, carrier_o falls after exactly OFF_FAST_MS*CYC_PER_MS consecutive edges (default 144).
- R6: A dropout below the turn-off threshold that is shorter than the turn-off count leaves carrier_o at 1.
- R7: With slow_rate_i at 1, the turn-on and turn-off counts are ON_SLOW_MS*CYC_PER_MS and OFF_SLOW_MS*CYC_PER_MS (default 512 each).
- R8: clamp_o is the inverse of carrier_o in every cycle. A value of 1 requests that received data be forced to mark.
- R9: With carrier_o at 0, a level strictly between the turn-off and turn-on thresholds never raises the flag.
- R10: When thresh_on_i is below HYST_STEPS, the turn-off threshold saturates at 0. A level of 0 is then never below it, so the flag cannot fall.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| level_i | input | LVL_W (8) | Received energy, 0.5 dB per step |
| thresh_on_i | input | LVL_W (8) | Turn-on threshold in the same scale |
| slow_rate_i | input | 1 | Selects the rate class: 0 is fast (18 ms), 1 is slow (64 ms) |
| carrier_o | output | 1 | Qualified carrier-present flag |
| clamp_o | output | 1 | Request to force received data to mark |

## Verification
The level is placed exactly on the turn-on threshold, exactly on the turn-off threshold, strictly between the two, and below the turn-off threshold. This shows that each comparison has the intended direction and inclusiveness, and that the thresholds are five steps apart.

Runs that are one edge short of the count and runs that reach the full count fix the exact qualification length for each rate class. A run broken by a single cycle shows that the count restarts rather than resumes. A dropout shorter than the turn-off count shows the ride-through behaviour.

A turn-on threshold below the hysteresis offset exercises the saturated turn-off threshold.

// File: rtl/cdq_pkg.sv
package cdq_pkg;
  // Turn-off threshold: turn-on threshold minus the hysteresis offset,
  // clamped at zero.
  function automatic int unsigned cdq_off_level(input int unsigned thr,
                                                input int unsigned hyst);
    return (thr > hyst) ? (thr - hyst) : 0;
  endfunction

  // Qualification length in clock cycles.
  function automatic int unsigned cdq_delay_cycles(input int unsigned ms,
                                                   input int unsigned cyc_per_ms);
    return ms * cyc_per_ms;
  endfunction

  // Larger of two counts.
  function automatic int unsigned cdq_max(input int unsigned a,
                                          input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/cdq_level_cmp.sv
module cdq_level_cmp #(
  parameter int LVL_W      = 8,
  parameter int HYST_STEPS = 5
) (
  input  logic [LVL_W-1:0] level_i,
  input  logic [LVL_W-1:0] thresh_on_i,
  output logic [LVL_W-1:0] thresh_off_o,
  output logic             above_on_o,
  output logic             below_off_o
);
  import cdq_pkg::*;

  always_comb begin
    thresh_off_o = LVL_W'(cdq_off_level(int'(thresh_on_i), HYST_STEPS));
    above_on_o   = (level_i >= thresh_on_i);
    below_off_o  = (level_i <  thresh_off_o);
  end

  // R4: the turn-off threshold never exceeds the turn-on threshold.
  always_comb begin
    p_off_below_on_r4 : assert (thresh_off_o <= thresh_on_i);
  end
endmodule

// File: rtl/cdq_qualify.sv
module cdq_qualify #(
  parameter int CNT_W    = 10,
  parameter int ON_FAST  = 144,
  parameter int OFF_FAST = 144,
  parameter int ON_SLOW  = 512,
  parameter int OFF_SLOW = 512
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic slow_rate_i,
  input  logic above_on_i,
  input  logic below_off_i,
  output logic carrier_o
);
  logic             carrier_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;
  logic             want_change;
  logic             count_done;

  // The condition that moves the flag depends on the current state.
  always_comb begin
    want_change = carrier_q ? below_off_i : above_on_i;
    if (slow_rate_i) limit = carrier_q ? CNT_W'(OFF_SLOW) : CNT_W'(ON_SLOW);
    else             limit = carrier_q ? CNT_W'(OFF_FAST) : CNT_W'(ON_FAST);
    count_done  = want_change && (cnt_q >= limit - CNT_W'(1));
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      carrier_q <= 1'b0;
      cnt_q     <= '0;
    end else if (!want_change) begin
      cnt_q <= '0;
    end else if (count_done) begin
      carrier_q <= ~carrier_q;
      cnt_q     <= '0;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign carrier_o = carrier_q;

  // R3: a cycle without the qualifying condition leaves the count at zero.
  p_restart_r3 : assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !want_change |=> (cnt_q == '0));

  // R2: the flag rises only after the level was at or above the turn-on threshold.
  p_rise_above_r2 : assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $rose(carrier_q) |-> $past(above_on_i));

  // R5: the flag falls only after the level was below the turn-off threshold.
  p_fall_below_r5 : assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $fell(carrier_q) |-> $past(below_off_i));

  // R7: a toggle happens only at the end of a full count for the selected class.
  p_full_count_r7 : assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (carrier_q != $past(carrier_q)) |-> ($past(cnt_q) == $past(limit) - CNT_W'(1)));
endmodule

// File: rtl/carrier_detect_qual.sv
module carrier_detect_qual #(
  parameter int LVL_W       = 8,
  parameter int HYST_STEPS  = 5,
  parameter int CYC_PER_MS  = 8,
  parameter int ON_FAST_MS  = 18,
  parameter int OFF_FAST_MS = 18,
  parameter int ON_SLOW_MS  = 64,
  parameter int OFF_SLOW_MS = 64
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic [LVL_W-1:0] level_i,
  input  logic [LVL_W-1:0] thresh_on_i,
  input  logic             slow_rate_i,
  output logic             carrier_o,
  output logic             clamp_o
);
  import cdq_pkg::*;

  localparam int unsigned ON_FAST  = cdq_delay_cycles(ON_FAST_MS,  CYC_PER_MS);
  localparam int unsigned OFF_FAST = cdq_delay_cycles(OFF_FAST_MS, CYC_PER_MS);
  localparam int unsigned ON_SLOW  = cdq_delay_cycles(ON_SLOW_MS,  CYC_PER_MS);
  localparam int unsigned OFF_SLOW = cdq_delay_cycles(OFF_SLOW_MS, CYC_PER_MS);
  localparam int unsigned MAX_CNT  =
    cdq_max(cdq_max(ON_FAST, OFF_FAST), cdq_max(ON_SLOW, OFF_SLOW));
  localparam int CNT_W = $clog2(MAX_CNT + 1) + 1;

  logic [LVL_W-1:0] thresh_off;
  logic             above_on;
  logic             below_off;
  logic             carrier;

  cdq_level_cmp #(.LVL_W(LVL_W), .HYST_STEPS(HYST_STEPS)) u_cmp (
    .level_i      (level_i),
    .thresh_on_i  (thresh_on_i),
    .thresh_off_o (thresh_off),
    .above_on_o   (above_on),
    .below_off_o  (below_off)
  );

  cdq_qualify #(
    .CNT_W   (CNT_W),
    .ON_FAST (int'(ON_FAST)),
    .OFF_FAST(int'(OFF_FAST)),
    .ON_SLOW (int'(ON_SLOW)),
    .OFF_SLOW(int'(OFF_SLOW))
  ) u_qual (
    .clk_i       (clk_i),
    .rst_n_i     (rst_n_i),
    .slow_rate_i (slow_rate_i),
    .above_on_i  (above_on),
    .below_off_i (below_off),
    .carrier_o   (carrier)
  );

  assign carrier_o = carrier;
  assign clamp_o   = ~carrier;

  // R1: the flag is low while reset is asserted.
  p_reset_low_r1 : assert property (@(posedge clk_i)
    !rst_n_i |-> !carrier_o);
endmodule

// File: tb/tb_carrier_detect_qual.sv
module tb_carrier_detect_qual;
  localparam int CLK_PERIOD = 10;
  localparam int FAST       = 18 * 8;
  localparam int SLOW       = 64 * 8;
  localparam int HYST       = 5;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] level;
  logic [7:0] thr;
  logic       slow;
  logic       carrier;
  logic       clamp;
  int         n_checks = 0;
  int         n_fail   = 0;
  bit         done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  carrier_detect_qual dut (
    .clk_i       (clk),
    .rst_n_i     (rst_n),
    .level_i     (level),
    .thresh_on_i (thr),
    .slow_rate_i (slow),
    .carrier_o   (carrier),
    .clamp_o     (clamp)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic exp_car);
    n_checks++;
    if (carrier !== exp_car || clamp !== ~exp_car) begin
      n_fail++;
      $display("FAIL %s: carrier=%b clamp=%b expected carrier=%b clamp=%b",
               req, carrier, clamp, exp_car, ~exp_car);
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0; level = 8'd200; thr = 8'd100; slow = 1'b0;
    step(3);
    check("R1 in reset", 1'b0);
    rst_n = 1'b1;
    step(5);
    check("R1 after reset", 1'b0);
    level = 8'd0;
    step(2);
  endtask

  task automatic t_fast_on;
    level = thr;
    step(FAST - 1);
    check("R2 one short", 1'b0);
    step(1);
    check("R2 on / R8 clamp", 1'b1);
  endtask

  task automatic t_hold_between;
    level = thr - 8'd4;
    step(300);
    check("R4 between", 1'b1);
    level = thr - 8'(HYST);
    step(300);
    check("R4 at off threshold", 1'b1);
  endtask

  task automatic t_dropout;
    level = thr - 8'(HYST) - 8'd1;
    step(FAST - 1);
    check("R6 dropout edge", 1'b1);
    level = thr + 8'd20;
    step(200);
    check("R6 ride through", 1'b1);
  endtask

  task automatic t_fast_off;
    level = thr - 8'(HYST) - 8'd1;
    step(FAST - 1);
    check("R5 one short", 1'b1);
    step(1);
    check("R5 off / R8 clamp", 1'b0);
  endtask

  task automatic t_between_off;
    level = thr - 8'd1;
    step(300);
    check("R9 between stays off", 1'b0);
  endtask

  task automatic t_restart;
    level = thr + 8'd10;
    step(100);
    level = thr - 8'd1;
    step(1);
    level = thr + 8'd10;
    step(FAST - 1);
    check("R3 restarted", 1'b0);
    step(1);
    check("R3 full run", 1'b1);
    level = 8'd0;
    step(FAST);
    check("R3 back off", 1'b0);
  endtask

  task automatic t_slow;
    slow = 1'b1;
    level = thr + 8'd10;
    step(SLOW - 1);
    check("R7 slow on short", 1'b0);
    step(1);
    check("R7 slow on", 1'b1);
    level = 8'd0;
    step(SLOW - 1);
    check("R7 slow off short", 1'b1);
    step(1);
    check("R7 slow off", 1'b0);
    slow = 1'b0;
  endtask

  task automatic t_saturate;
    thr = 8'd3;
    level = 8'd3;
    step(FAST);
    check("R10 on at low threshold", 1'b1);
    level = 8'd0;
    step(300);
    check("R10 saturated off threshold", 1'b1);
  endtask

  initial begin
    t_reset();
    t_fast_on();
    t_hold_between();
    t_dropout();
    t_fast_off();
    t_between_off();
    t_restart();
    t_slow();
    t_saturate();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule